// File: doc/BRIEF.md
# UART Transmitter with Low-Water Queue

This block turns bytes written by software into asynchronous serial frames. Each written byte enters a 32-deep first-in first-out queue. A framing state machine pops one byte at a time and shifts it onto the serial line. A separate baud generator supplies a one-cycle pulse at sixteen times the bit rate, and the state machine advances only on that pulse. Three configuration inputs set the frame shape: the number of data bits (7 or 8), the number of stop bits (1 or 2), and parity (off, odd or even). The state machine samples this configuration when it takes a byte from the queue, so each frame uses a single format from start to end.

Software sets a trigger level for refilling. This level is a count of bytes still waiting in the queue, not a count of free slots. The ready flag is high whenever the queue holds that many bytes or fewer. The interrupt output is the ready flag gated by an interrupt-enable input. A driver normally clears that enable while it services the interrupt. A separate completion flag goes high once the queue is empty and no frame is in flight.

The state machine has five states:
- IDLE: the line is held high.
- START: the start bit is sent.
- DATA: the data bits are sent.
- PARITY: the parity bit is sent.
- STOP: the stop bits are sent.

The transitions between them are:
- IDLE→START: the queue is not empty. The byte is popped and loaded into the shifter.
- START→DATA: the start bit ends.
- DATA→PARITY: the last data bit ends and parity is on.
- DATA→STOP: the last data bit ends and parity is off.
- PARITY→STOP: the parity bit ends.
- STOP→IDLE: the last stop bit ends.

Top module: `uart_tx_lowwater`

## Requirements
- R1: After reset, `txd` is high, `fifo_level` is 0 and `tx_done` is 1. The line stays high whenever no frame is being sent.
- R2: A frame is a low start bit, then the data bits least-significant first, then the optional parity bit, then the high stop bit(s). Every bit lasts exactly 16 `tick_16x` pulses, and `txd` changes only in the cycle after a tick or when a frame starts.
- R3: `cfg_word8` = 1 sends 8 data bits. `cfg_word8` = 0 sends 7 data bits, and bit 7 of the byte is not transmitted.
- R4: `cfg_stop2` = 1 sends 2 stop bits and `cfg_stop2` = 0 sends 1 stop bit.
- R5: With `cfg_par_en` = 1, a parity bit follows the data bits. With `cfg_par_even` = 1 the parity makes the count of ones in the data bits plus the parity bit even; with `cfg_par_even` = 0 it makes that count odd. With `cfg_par_en` = 0 no parity bit is sent.
- R6: The queue holds 32 bytes and sends them in write order. A write while the queue holds 32 bytes is discarded, and `fifo_level` stays at 32.
- R7: `tx_ready` is 1 exactly when `fifo_level` is less than or equal to `tx_trig_lvl`.
- R8: `tx_irq` is 1 only when `tx_ready` is 1 and `tx_irq_en` is 1.
- R9: `tx_done` is 1 exactly when the queue is empty and the framer is in IDLE. It is 0 while any byte is queued or being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to queue |
| cfg_word8 | input | 1 | 1: 8 data bits; 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits; 0: one stop bit |
| cfg_par_en | input | 1 | Adds a parity bit when 1 |
| cfg_par_even | input | 1 | 1: even parity; 0: odd parity |
| tx_trig_lvl | input | $clog2(DEPTH+1) | Trigger level, counted as bytes still queued |
| tx_irq_en | input | 1 | Enables the interrupt output |
| txd | output | 1 | Serial line, high when idle |
| tx_ready | output | 1 | Queue has drained to the trigger level or below |
| tx_irq | output | 1 | Gated ready interrupt |
| tx_done | output | 1 | Queue empty and no frame in flight |
| fifo_level | output | $clog2(DEPTH+1) | Bytes waiting in the queue |

## Verification
The bench decodes the serial line by sampling at the centre of each bit. It sends several kinds of input:
- A directed 8-bit frame with no parity checks bit order and start and stop polarity.
- Random batches of random bytes under random frame formats check the 7-bit and 8-bit widths, the parity sense and the stop count. They also separate the queueing order from the per-frame format.
- A burst of 34 writes while ticks are paused fills the queue past capacity. Draining it then shows which write was dropped.
- A paused queue set to exactly the trigger level, and then one byte above it, tests the inclusive boundary of the ready comparison and the interrupt gate.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic word8;
        logic stop2;
        logic par_en;
        logic par_even;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic             do_push, do_pop;

    assign empty     = (level_q == '0);
    assign full      = (level_q == LVL_W'(DEPTH));
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_data = mem[rd_ptr_q];
    assign level     = level_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= bump(wr_ptr_q);
            end
            if (do_pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            unique case ({do_push, do_pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_watermark.sv
module uart_tx_watermark #(
    parameter int LVL_W = 6
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    input  logic             irq_en,
    output logic             ready,
    output logic             irq
);

    // The trigger counts bytes still queued, so the comparison is inclusive.
    always_comb begin
        ready = (level <= trig);
        irq   = ready && irq_en;
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int OS = 16,
    localparam int OS_W = (OS > 1) ? $clog2(OS) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    input  frame_cfg_t cfg,
    output logic       pop,
    output logic       txd,
    output logic       busy
);

    tx_state_e   state_q, state_d;
    logic [OS_W-1:0] os_q;
    logic [2:0]  cnt_q;
    logic [7:0]  sh_q;
    logic        par_q;
    frame_cfg_t  cfg_q;
    logic        bit_end, last_data, last_stop, load;
    logic [7:0]  masked;

    assign bit_end   = tick && (os_q == OS_W'(OS - 1));
    assign last_data = (cnt_q == (cfg_q.word8 ? 3'd7 : 3'd6));
    assign last_stop = (cnt_q == (cfg_q.stop2 ? 3'd1 : 3'd0));
    assign load      = (state_q == ST_IDLE) && !fifo_empty;
    assign masked    = cfg.word8 ? fifo_data : {1'b0, fifo_data[6:0]};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load)    state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && last_data)
                           state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (bit_end && last_stop) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath: oversample counter, bit counter, shifter, latched format
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_q  <= '0;
            cnt_q <= '0;
            sh_q  <= '0;
            par_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                os_q <= '0;
            end else if (tick) begin
                os_q <= (os_q == OS_W'(OS - 1)) ? '0 : os_q + 1'b1;
            end

            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (bit_end) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (load) begin
                sh_q  <= fifo_data;
                cfg_q <= cfg;
                par_q <= cfg.par_even ? ^masked : ~^masked;
            end else if ((state_q == ST_DATA) && bit_end) begin
                sh_q <= {1'b0, sh_q[7:1]};
            end
        end
    end

    // Outputs
    always_comb begin
        pop  = load;
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh_q[0];
            ST_PARITY: txd = par_q;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_lowwater.sv
module uart_tx_lowwater
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int OS    = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_16x,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             cfg_word8,
    input  logic             cfg_stop2,
    input  logic             cfg_par_en,
    input  logic             cfg_par_even,
    input  logic [LVL_W-1:0] tx_trig_lvl,
    input  logic             tx_irq_en,
    output logic             txd,
    output logic             tx_ready,
    output logic             tx_irq,
    output logic             tx_done,
    output logic [LVL_W-1:0] fifo_level
);

    logic       fifo_empty, fifo_full, fr_pop, fr_busy;
    logic [7:0] head;
    frame_cfg_t cfg;

    assign cfg = '{word8: cfg_word8, stop2: cfg_stop2,
                   par_en: cfg_par_en, par_even: cfg_par_even};

    uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (fr_pop),
        .head_data (head),
        .level     (fifo_level),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    uart_tx_framer #(.OS(OS)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_16x),
        .fifo_empty (fifo_empty),
        .fifo_data  (head),
        .cfg        (cfg),
        .pop        (fr_pop),
        .txd        (txd),
        .busy       (fr_busy)
    );

    uart_tx_watermark #(.LVL_W(LVL_W)) u_mark (
        .level  (fifo_level),
        .trig   (tx_trig_lvl),
        .irq_en (tx_irq_en),
        .ready  (tx_ready),
        .irq    (tx_irq)
    );

    assign tx_done = fifo_empty && !fr_busy;

endmodule

// File: rtl/uart_tx_lowwater_chk.sv
module uart_tx_lowwater_chk #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_16x,
    input logic             wr_en,
    input logic             tx_irq_en,
    input logic [LVL_W-1:0] tx_trig_lvl,
    input logic [LVL_W-1:0] fifo_level,
    input logic             tx_ready,
    input logic             tx_irq,
    input logic             tx_done,
    input logic             txd,
    input logic             fr_busy
);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);

    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_busy && $past(fr_busy) && !$past(tick_16x)) |-> $stable(txd));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH) && wr_en)
        |=> (fifo_level == LVL_W'(DEPTH) || fifo_level == LVL_W'(DEPTH - 1)));

    p_above_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level > tx_trig_lvl) |-> !tx_ready);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_irq_en |-> !tx_irq);

    p_done_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (fifo_level == '0));

endmodule

bind uart_tx_lowwater uart_tx_lowwater_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_16x    (tick_16x),
    .wr_en       (wr_en),
    .tx_irq_en   (tx_irq_en),
    .tx_trig_lvl (tx_trig_lvl),
    .fifo_level  (fifo_level),
    .tx_ready    (tx_ready),
    .tx_irq      (tx_irq),
    .tx_done     (tx_done),
    .txd         (txd),
    .fr_busy     (fr_busy)
);

// File: tb/uart_tx_lowwater_bench.sv
module uart_tx_lowwater_bench;

    localparam int DEPTH = 32;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int TD    = 4;
    localparam int BITC  = 16 * TD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_16x = 1'b0;
    logic tick_run = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic cfg_word8 = 1'b1, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_even = 1'b0;
    logic [LVL_W-1:0] tx_trig_lvl = LVL_W'(8);
    logic tx_irq_en = 1'b0;
    logic txd, tx_ready, tx_irq, tx_done;
    logic [LVL_W-1:0] fifo_level;

    int n_checks = 0;
    int n_fail = 0;
    int tick_cnt = 0;
    logic [7:0] bytes [40];

    uart_tx_lowwater u_uart_tx_lowwater (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_word8(cfg_word8), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .tx_trig_lvl(tx_trig_lvl), .tx_irq_en(tx_irq_en),
        .txd(txd), .tx_ready(tx_ready), .tx_irq(tx_irq), .tx_done(tx_done),
        .fifo_level(fifo_level)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (tick_run) begin
            tick_16x <= (tick_cnt == TD - 1);
            tick_cnt <= (tick_cnt == TD - 1) ? 0 : tick_cnt + 1;
        end else begin
            tick_16x <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic exp_par(input logic [7:0] b, input logic w8, input logic even);
        logic [7:0] m;
        m = w8 ? b : {1'b0, b[6:0]};
        return even ? ^m : ~^m;
    endfunction

    task automatic write_byte(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic recv_frame(input logic [7:0] exp);
        logic [7:0] got;
        int nbits;
        got = '0;
        nbits = cfg_word8 ? 8 : 7;
        while (txd) @(negedge clk);
        repeat (BITC / 2) @(negedge clk);
        check(txd == 1'b0, "R2 start bit", int'(txd), 0);
        for (int i = 0; i < nbits; i++) begin
            repeat (BITC) @(negedge clk);
            got[i] = txd;
        end
        check(got == (cfg_word8 ? exp : {1'b0, exp[6:0]}), "R3 data bits", int'(got),
              int'(cfg_word8 ? exp : {1'b0, exp[6:0]}));
        if (cfg_par_en) begin
            repeat (BITC) @(negedge clk);
            check(txd == exp_par(exp, cfg_word8, cfg_par_even), "R5 parity bit",
                  int'(txd), int'(exp_par(exp, cfg_word8, cfg_par_even)));
        end
        for (int s = 0; s < (cfg_stop2 ? 2 : 1); s++) begin
            repeat (BITC) @(negedge clk);
            check(txd == 1'b1, "R4 stop bit", int'(txd), 1);
        end
    endtask

    task automatic run_batch(input int n);
        fork
            begin
                for (int i = 0; i < n; i++) write_byte(bytes[i]);
                check(tx_done == 1'b0, "R9 busy while sending", int'(tx_done), 0);
            end
            begin
                for (int i = 0; i < n; i++) recv_frame(bytes[i]);
            end
        join
        repeat (BITC) @(negedge clk);
        check(tx_done == 1'b1, "R9 done after drain", int'(tx_done), 1);
        check(txd == 1'b1, "R1 idle line high", int'(txd), 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h1BADF00D));
        do_reset();

        // R1 / R7 / R8 reset state
        check(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
        check(fifo_level == '0, "R1 level after reset", int'(fifo_level), 0);
        check(tx_done == 1'b1, "R1 done after reset", int'(tx_done), 1);
        check(tx_ready == 1'b1, "R7 ready when empty", int'(tx_ready), 1);
        check(tx_irq == 1'b0, "R8 irq gated off", int'(tx_irq), 0);

        // Directed 8N1 frame
        bytes[0] = 8'hA5;
        run_batch(1);

        // Random formats and bytes
        for (int b = 0; b < 6; b++) begin
            int n;
            cfg_word8    = 1'($urandom() % 2);
            cfg_stop2    = 1'($urandom() % 2);
            cfg_par_en   = 1'($urandom() % 2);
            cfg_par_even = 1'($urandom() % 2);
            if (b == 0) begin cfg_word8 = 1'b0; cfg_par_en = 1'b1; cfg_par_even = 1'b1; end
            if (b == 1) begin cfg_stop2 = 1'b1; cfg_par_en = 1'b1; cfg_par_even = 1'b0; end
            n = 1 + int'($urandom() % 6);
            for (int i = 0; i < n; i++) bytes[i] = 8'($urandom());
            bytes[0][7] = 1'b1;
            run_batch(n);
        end

        // R7 / R8 trigger boundary with ticks paused
        cfg_word8 = 1'b1; cfg_stop2 = 1'b0; cfg_par_en = 1'b0;
        tick_run = 1'b0;
        do_reset();
        tx_trig_lvl = LVL_W'(8);
        tx_irq_en = 1'b1;
        for (int i = 0; i < 9; i++) write_byte(8'(i));
        @(negedge clk);
        check(fifo_level == LVL_W'(8), "R6 level count", int'(fifo_level), 8);
        check(tx_ready == 1'b1, "R7 ready at trigger", int'(tx_ready), 1);
        check(tx_irq == 1'b1, "R8 irq when enabled", int'(tx_irq), 1);
        tx_irq_en = 1'b0;
        @(negedge clk);
        check(tx_irq == 1'b0, "R8 irq cleared by enable", int'(tx_irq), 0);
        tx_irq_en = 1'b1;
        write_byte(8'h55);
        check(tx_ready == 1'b0, "R7 not ready above trigger", int'(tx_ready), 0);
        check(tx_irq == 1'b0, "R8 no irq above trigger", int'(tx_irq), 0);
        tx_irq_en = 1'b0;

        // R6 overflow: 34 writes, first goes to the shifter, last is dropped
        do_reset();
        for (int i = 0; i < 34; i++) write_byte(8'(i * 7 + 3));
        @(negedge clk);
        check(fifo_level == LVL_W'(32), "R6 level capped at 32", int'(fifo_level), 32);
        tx_trig_lvl = LVL_W'(31);
        @(negedge clk);
        check(tx_ready == 1'b0, "R7 full above trigger", int'(tx_ready), 0);
        tx_trig_lvl = LVL_W'(32);
        @(negedge clk);
        check(tx_ready == 1'b1, "R7 full at trigger", int'(tx_ready), 1);
        tx_trig_lvl = LVL_W'(8);
        tick_run = 1'b1;
        for (int i = 0; i < 33; i++) recv_frame(8'(i * 7 + 3));
        repeat (BITC) @(negedge clk);
        check(tx_done == 1'b1, "R6 dropped write not sent", int'(tx_done), 1);
        check(fifo_level == '0, "R6 queue empty after drain", int'(fifo_level), 0);

        finish_run();
    end

endmodule